// File: doc/BRIEF.md
# Packed-Lane Rounding Variable Shifter

This combinational SIMD unit shifts every lane of a 64-bit data word by its own signed count. A size input selects lanes of 8, 16, 32 or 64 bits. A mode input chooses whether lane contents are two's-complement or unsigned. The count for a lane is the least significant byte of the matching lane of a second 64-bit control word.

Counts of zero or above shift left. Negative counts perform a right shift that rounds to nearest, with ties rounded upward. The unit adds half of the last kept bit before it shifts. That addition is computed one bit wider than the lane, so it cannot overflow even in a 64-bit lane.

Counts at or past the lane width in either direction produce fixed, mode-dependent results. Each lane is evaluated independently, and no bit crosses between neighbouring lanes.

Top module: `rshl_simd`

## Requirements
- R1: A lane's count is bits [7:0] of the matching control lane, read as a signed two's-complement byte. All higher control bits of that lane have no effect on the result.
- R2: A count n with 0 <= n < lane width yields the lane data shifted left by n places, with zeros entering from the bottom. Bits leaving the top are discarded.
- R3: A count n >= lane width yields an all-zero lane in both modes.
- R4: In signed mode (sgn_i = 1), a count n < -width fills the whole lane with copies of its top bit.
- R5: In unsigned mode (sgn_i = 0), a count n < -width yields zero.
- R6: In unsigned mode, a count n = -width yields the lane's top bit placed at bit 0, with every other bit zero.
- R7: In signed mode, a count n = -width yields zero, whatever the data.
- R8: For -width < n < 0, the result is (x + 2^(-n-1)) shifted right by -n. The shift is arithmetic when sgn_i = 1 and logical when sgn_i = 0.
- R9: The rounding sum never overflows. With a count of -1 in a 64-bit lane, 0xFFFFFFFFFFFFFFFF (unsigned) gives 0x8000000000000000. 0x7FFFFFFFFFFFFFFF (signed) gives 0x4000000000000000. A non-negative signed lane never produces a negative result.
- R10: size_i encodes the lane width: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. Lane i occupies bits [i*width +: width]. Each lane's result depends only on its own data lane and control lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| size_i | input | 2 | Lane width select (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| sgn_i | input | 1 | 1: lanes are two's-complement, 0: lanes are unsigned |
| data_i | input | 64 | Packed data lanes |
| ctrl_i | input | 64 | Packed control lanes; low byte of each holds the signed count |
| result_o | output | 64 | Packed shifted lanes |

## Verification
The bench uses the default 64-bit datapath parameter. All four lane-width banks are therefore elaborated and reachable through size_i. Sweeping the full count byte from -128 to +127 covers every region in every width, including the 64-bit lane: plain left shift, zeroing, the exact minus-width count, fill below minus width, and rounding. Those counts are applied to zero, one, all-ones, the most positive and the most negative lane values. Directed cases also drive different counts into neighbouring lanes and put junk in the upper control bits.

// File: rtl/rshl_pkg.sv
package rshl_pkg;

    localparam int CNT_W = 8;
    localparam int NUM_CLASSES = 4;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B64 = 2'd3
    } lane_size_e;

    typedef enum logic [1:0] {
        OP_CLEAR,
        OP_LEFT,
        OP_FILL,
        OP_ROUND
    } shift_op_e;

    typedef struct packed {
        shift_op_e        op;
        logic [CNT_W-1:0] amt;
    } shift_cmd_t;

    function automatic int class_width(input int idx);
        return 8 << idx;
    endfunction

endpackage

// File: rtl/rshl_count_dec.sv
module rshl_count_dec
    import rshl_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [CNT_W-1:0] cnt_i,
    output shift_cmd_t       cmd_o
);
    localparam logic signed [9:0] WIDTH_S = 10'(LANE_W);

    logic signed [9:0] cnt_s;
    logic signed [9:0] mag_s;

    assign cnt_s = {{2{cnt_i[CNT_W-1]}}, cnt_i};
    assign mag_s = -cnt_s;

    always_comb begin
        cmd_o.op  = OP_CLEAR;
        cmd_o.amt = '0;
        if (cnt_s >= WIDTH_S) begin
            cmd_o.op = OP_CLEAR;
        end else if (cnt_s >= 10'sd0) begin
            cmd_o.op  = OP_LEFT;
            cmd_o.amt = cnt_i;
        end else if (cnt_s < -WIDTH_S) begin
            cmd_o.op = OP_FILL;
        end else begin
            cmd_o.op  = OP_ROUND;
            cmd_o.amt = mag_s[CNT_W-1:0];
        end
    end

    // R8: a rounding command always carries a distance from 1 up to the lane width
    always_comb begin
        if (!$isunknown(cnt_i) && cmd_o.op == OP_ROUND) begin
            assert_round_amt_R8: assert (cmd_o.amt != '0 && int'(cmd_o.amt) <= LANE_W);
        end
    end

endmodule

// File: rtl/rshl_round_right.sv
module rshl_round_right
    import rshl_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] data_i,
    input  logic              sgn_i,
    input  logic [CNT_W-1:0]  amt_i,
    output logic [LANE_W-1:0] res_o
);
    localparam int EXT_W = LANE_W + 1;

    logic [EXT_W-1:0]        ext_val;
    logic [EXT_W-1:0]        bias;
    logic [EXT_W-1:0]        sum;
    logic signed [EXT_W-1:0] shifted;
    logic [CNT_W-1:0]        bias_pos;

    assign ext_val  = {sgn_i & data_i[LANE_W-1], data_i};
    assign bias_pos = amt_i - CNT_W'(1);

    always_comb begin
        if (amt_i == '0) begin
            bias = '0;
        end else begin
            bias = EXT_W'(1) << bias_pos;
        end
    end

    assign sum = ext_val + bias;

    always_comb begin
        if (sgn_i) begin
            shifted = $signed(sum) >>> amt_i;
        end else begin
            shifted = $signed(sum >> amt_i);
        end
    end

    assign res_o = shifted[LANE_W-1:0];

    // R9: rounding a non-negative signed lane can never wrap to negative
    always_comb begin
        if (!$isunknown({data_i, sgn_i, amt_i}) && sgn_i && !data_i[LANE_W-1] && amt_i != '0) begin
            assert_no_overflow_R9: assert (!res_o[LANE_W-1]);
        end
    end

    // R8: an unsigned shift by two or more clears the top result bit
    always_comb begin
        if (!$isunknown({data_i, sgn_i, amt_i}) && !sgn_i && amt_i >= CNT_W'(2)) begin
            assert_unsigned_top_R8: assert (!res_o[LANE_W-1]);
        end
    end

endmodule

// File: rtl/rshl_lane.sv
module rshl_lane
    import rshl_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] data_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              sgn_i,
    output logic [LANE_W-1:0] res_o
);
    localparam logic signed [9:0] WIDTH_S = 10'(LANE_W);

    shift_cmd_t        cmd;
    logic [LANE_W-1:0] round_res;
    logic [LANE_W-1:0] left_res;
    logic [LANE_W-1:0] fill_res;
    logic signed [9:0] cnt_s;

    assign cnt_s = {{2{cnt_i[CNT_W-1]}}, cnt_i};

    rshl_count_dec #(.LANE_W(LANE_W)) u_dec (
        .cnt_i (cnt_i),
        .cmd_o (cmd)
    );

    rshl_round_right #(.LANE_W(LANE_W)) u_round (
        .data_i (data_i),
        .sgn_i  (sgn_i),
        .amt_i  (cmd.amt),
        .res_o  (round_res)
    );

    assign left_res = data_i << cmd.amt;
    assign fill_res = {LANE_W{sgn_i & data_i[LANE_W-1]}};

    always_comb begin
        unique case (cmd.op)
            OP_LEFT:  res_o = left_res;
            OP_FILL:  res_o = fill_res;
            OP_ROUND: res_o = round_res;
            default:  res_o = '0;
        endcase
    end

    logic lane_known;
    assign lane_known = !$isunknown({data_i, cnt_i, sgn_i});

    // R3: counts at or beyond the width clear the lane
    always_comb begin
        if (lane_known && cnt_s >= WIDTH_S) begin
            assert_wide_left_zero_R3: assert (res_o == '0);
        end
    end

    // R4 / R5: counts below minus the width give sign fill or zero
    always_comb begin
        if (lane_known && cnt_s < -WIDTH_S) begin
            if (sgn_i) begin
                assert_sign_fill_R4: assert (res_o == '0 || res_o == '1);
            end else begin
                assert_unsigned_deep_R5: assert (res_o == '0);
            end
        end
    end

    // R6 / R7: a count of exactly minus the width
    always_comb begin
        if (lane_known && cnt_s == -WIDTH_S) begin
            if (sgn_i) begin
                assert_signed_edge_R7: assert (res_o == '0);
            end else begin
                assert_unsigned_edge_R6: assert (res_o == LANE_W'(data_i[LANE_W-1]));
            end
        end
    end

endmodule

// File: rtl/rshl_simd.sv
module rshl_simd
    import rshl_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        size_i,
    input  logic              sgn_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] ctrl_i,
    output logic [DATA_W-1:0] result_o
);
    logic [DATA_W-1:0] class_res [NUM_CLASSES];

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_class
        localparam int LW = class_width(g);
        localparam int NL = DATA_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            rshl_lane #(.LANE_W(LW)) u_lane (
                .data_i (data_i[l*LW +: LW]),
                .cnt_i  (ctrl_i[l*LW +: CNT_W]),
                .sgn_i  (sgn_i),
                .res_o  (class_res[g][l*LW +: LW])
            );
        end
    end

    assign result_o = class_res[size_i];

    // R2: a zero count in every lane passes the data through unchanged
    always_comb begin
        if (!$isunknown({size_i, sgn_i, data_i, ctrl_i}) && ctrl_i == '0) begin
            assert_zero_count_pass_R2: assert (result_o == data_i);
        end
    end

endmodule

// File: tb/tb_rshl_simd.sv
module tb_rshl_simd;

    logic        clk = 1'b0;
    logic [1:0]  size_i = '0;
    logic        sgn_i = 1'b0;
    logic [63:0] data_i = '0;
    logic [63:0] ctrl_i = '0;
    logic [63:0] result_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    rshl_simd #(.DATA_W(64)) dut (
        .size_i   (size_i),
        .sgn_i    (sgn_i),
        .data_i   (data_i),
        .ctrl_i   (ctrl_i),
        .result_o (result_o)
    );

    function automatic logic [63:0] lane_mask(input int w);
        return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] ref_lane(input logic [63:0] xin, input int w,
                                             input logic [7:0] cb, input bit sg);
        int n;
        int k;
        logic [63:0] m;
        logic [63:0] x;
        logic top;
        logic signed [129:0] v;
        n = int'($signed(cb));
        m = lane_mask(w);
        x = xin & m;
        top = x[w-1];
        if (n >= w) return 64'd0;
        if (n >= 0) return (x << n) & m;
        if (n < -w) return (sg && top) ? m : 64'd0;
        if (n == -w) return sg ? 64'd0 : {63'd0, top};
        k = -n;
        v = $signed({66'd0, x});
        if (sg && top) v = v - (130'sd1 <<< w);
        v = v + (130'sd1 <<< (k - 1));
        v = v >>> k;
        return v[63:0] & m;
    endfunction

    function automatic logic [63:0] ref_vec(input logic [1:0] sz, input bit sg,
                                            input logic [63:0] d, input logic [63:0] c);
        int w;
        logic [63:0] r;
        logic [63:0] m;
        w = 8 << sz;
        m = lane_mask(w);
        r = '0;
        for (int l = 0; l < 64 / w; l++) begin
            r |= (ref_lane((d >> (l * w)) & m, w, c[l*w +: 8], sg) & m) << (l * w);
        end
        return r;
    endfunction

    task automatic apply_check(input string tag, input logic [1:0] sz, input bit sg,
                               input logic [63:0] d, input logic [63:0] c,
                               input logic [63:0] exp);
        @(posedge clk);
        #1;
        size_i = sz;
        sgn_i  = sg;
        data_i = d;
        ctrl_i = c;
        #1;
        n_checks++;
        if (result_o !== exp) begin
            n_fails++;
            $display("FAIL %s size=%0d sgn=%0d data=%h ctrl=%h got=%h exp=%h",
                     tag, sz, sg, d, c, result_o, exp);
        end
    endtask

    task automatic t_idle;
        apply_check("R2 idle zero inputs", 2'd0, 1'b0, 64'd0, 64'd0, 64'd0);
        apply_check("R2 zero count passes data", 2'd3, 1'b1,
                    64'h8123_4567_89AB_CDEF, 64'd0, 64'h8123_4567_89AB_CDEF);
    endtask

    task automatic t_left;
        apply_check("R2 R10 byte lanes left by one", 2'd0, 1'b0,
                    64'h0102_0408_1020_4080, 64'h0101_0101_0101_0101,
                    64'h0204_0810_2040_8000);
        apply_check("R2 halfword lanes left by four", 2'd1, 1'b1,
                    64'h1234_5678_9ABC_DEF0, 64'h0004_0004_0004_0004,
                    64'h2340_6780_ABC0_EF00);
    endtask

    task automatic t_round;
        apply_check("R8 signed byte rounding", 2'd0, 1'b1,
                    64'h0000_0000_0000_FB05, 64'hFFFF_FFFF_FFFF_FFFF,
                    64'h0000_0000_0000_FE03);
        apply_check("R8 unsigned byte rounding", 2'd0, 1'b0,
                    64'h0000_0000_0000_00FF, 64'hFFFF_FFFF_FFFF_FFFF,
                    64'h0000_0000_0000_0080);
    endtask

    task automatic t_range;
        apply_check("R3 R4 signed word out of range", 2'd2, 1'b1,
                    64'h8000_0000_7FFF_FFFF, 64'h0000_00DF_0000_0020,
                    64'hFFFF_FFFF_0000_0000);
        apply_check("R3 R5 unsigned word out of range", 2'd2, 1'b0,
                    64'h8000_0000_7FFF_FFFF, 64'h0000_00DF_0000_0020,
                    64'h0000_0000_0000_0000);
        apply_check("R6 unsigned word minus width", 2'd2, 1'b0,
                    64'h8000_0000_7FFF_FFFF, 64'h0000_00E0_0000_00E0,
                    64'h0000_0001_0000_0000);
        apply_check("R7 signed word minus width", 2'd2, 1'b1,
                    64'h8000_0000_7FFF_FFFF, 64'h0000_00E0_0000_00E0,
                    64'h0000_0000_0000_0000);
    endtask

    task automatic t_corner;
        apply_check("R9 unsigned max by -1", 2'd3, 1'b0,
                    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00FF,
                    64'h8000_0000_0000_0000);
        apply_check("R9 signed max by -1", 2'd3, 1'b1,
                    64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00FF,
                    64'h4000_0000_0000_0000);
        apply_check("R9 signed min by -1", 2'd3, 1'b1,
                    64'h8000_0000_0000_0000, 64'h0000_0000_0000_00FF,
                    64'hC000_0000_0000_0000);
    endtask

    task automatic t_ctrl_high;
        apply_check("R1 junk above count left", 2'd3, 1'b0,
                    64'd1, 64'hDEAD_BEEF_1234_5602, 64'd4);
        apply_check("R1 junk above count right", 2'd3, 1'b1,
                    64'd6, 64'hA5A5_0F0F_C3C3_99FE, 64'd2);
    endtask

    task automatic t_isolation;
        apply_check("R10 mixed counts per halfword lane", 2'd1, 1'b0,
                    64'hFFFF_FFFF_FFFF_FFFF, 64'h00F0_0010_00FF_0001,
                    64'h0001_0000_8000_FFFE);
    endtask

    task automatic t_sweep;
        logic [63:0] d;
        logic [63:0] c;
        logic [63:0] m;
        logic [63:0] lane_val;
        logic [63:0] extremes [5];
        int w;
        for (int sz = 0; sz < 4; sz++) begin
            w = 8 << sz;
            m = lane_mask(w);
            extremes[0] = 64'd0;
            extremes[1] = 64'd1;
            extremes[2] = m;
            extremes[3] = m >> 1;
            extremes[4] = (m >> 1) ^ m;
            for (int sg = 0; sg < 2; sg++) begin
                for (int e = 0; e < 5; e++) begin
                    for (int cv = -128; cv < 128; cv++) begin
                        d = '0;
                        c = '0;
                        for (int l = 0; l < 64 / w; l++) begin
                            lane_val = extremes[e];
                            d |= lane_val << (l * w);
                            c |= (((64'h5A3C_96E1_7B2D_C48F & m) & ~64'hFF)
                                  | {56'd0, 8'(cv)}) << (l * w);
                        end
                        apply_check("R8 sweep", 2'(sz), 1'(sg), d, c,
                                    ref_vec(2'(sz), 1'(sg), d, c));
                    end
                end
            end
        end
    endtask

    initial begin
        #400000;
        n_fails++;
        $display("FAIL watchdog expired, checks=%0d got=timeout exp=finish", n_checks);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_idle();
        t_left();
        t_round();
        t_range();
        t_corner();
        t_ctrl_high();
        t_isolation();
        t_sweep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule